// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

The controller decides when the CPU clock is gated off and which low-power state the chip occupies. Software issues a write to a low-power control register that carries three request bits: a doze bit, a halt bit and a timer-off bit (timer-off = 0 keeps only the timebase timer running). A clock-source input reports whether the chip runs from the main oscillator or from the PLL. The controller decodes the write and moves from run into PLL sleep, main sleep, stop or timebase-timer mode. It drives a CPU clock enable, a one-hot state word and a per-pin hold enable. The hold enable never covers the pins that carry bus data or bus control.

An entry is refused when an interrupt request is pending in the cycle of the write. Any low-power state is left when an interrupt request arrives, or by reset. Reset returns the controller to its reset state. Peripheral clocks are not touched. Data state is never cleared on entry. Oscillator, PLL and wake-up stabilization timing are not modelled.

Top module: `lpm_entry_ctrl`

## Requirements
- R1: After reset the state word is 5'b00001 (run), `cpu_clk_en` is 1 and `pin_hold` is all zero.
- R2: In run, a write with doze=1, timer-off=1 and halt=0 and no pending interrupt enters PLL sleep (state 5'b00010) when `clk_src_main`=0, and main sleep (state 5'b00100) when `clk_src_main`=1. The new state is visible after the clock edge that samples the write.
- R3: In run, a write with halt=1 and no pending interrupt enters stop (state 5'b01000), whatever the doze and timer-off bits hold.
- R4: In run, a write with doze=1, timer-off=0 and halt=0 and no pending interrupt enters timebase-timer mode (state 5'b10000). This overrides the sleep decode.
- R5: A write with doze=0 and halt=0 leaves the state unchanged.
- R6: A write that samples `irq_pending`=1 in the same cycle causes no entry, and the state stays run.
- R7: `cpu_clk_en` is 1 in run and 0 in every other state.
- R8: In any low-power state, `pin_hold` equals the bitwise inverse of `BUS_PIN_MASK`. In run it is zero.
- R9: In a low-power state, `irq_pending`=1 at a clock edge returns the state to run after that edge, and this re-enables the CPU clock.
- R10: Asserting `rst_n` low in a low-power state returns the state to run at once, without waiting for a clock edge.
- R11: Writes sampled outside run have no effect on the state.
- R12: The state word always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Strobe for a write to the low-power control register |
| wr_doze | input | 1 | Doze request bit of the written value |
| wr_halt | input | 1 | Halt request bit of the written value |
| wr_tb_off | input | 1 | Timer-off bit; 0 selects timebase-timer mode |
| clk_src_main | input | 1 | 1 when the main oscillator clocks the chip, 0 for PLL |
| irq_pending | input | 1 | An interrupt request is pending |
| cpu_clk_en | output | 1 | Enable for the CPU clock gate |
| state_onehot | output | 5 | One-hot state: bit0 run, bit1 PLL sleep, bit2 main sleep, bit3 stop, bit4 timebase |
| pin_hold | output | NPINS | Per-pin hold enable; bus pins are always excluded |

## Verification
An entry write and an interrupt request can arrive in the same cycle. In that case the refusal path must win over the decode path. The bench provokes this with doze-only and halt writes that carry `irq_pending`=1, and expects the state to stay run with the clock enabled after that edge. A second coincidence is a write that arrives while the controller is already asleep together with the wake interrupt. The bench expects run after that edge and never the newly written target.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LP_NSTATES = 5;

  typedef enum logic [LP_NSTATES-1:0] {
    LP_RUN       = 5'b00001,
    LP_SLEEP_PLL = 5'b00010,
    LP_SLEEP_MN  = 5'b00100,
    LP_STOP      = 5'b01000,
    LP_TIMEBASE  = 5'b10000
  } lp_state_e;

  typedef struct packed {
    logic      valid;
    lp_state_e target;
  } lp_entry_t;

  // Halt dominates; then timer-off=0 picks timebase; then doze picks a sleep
  // flavour from the clock source.
  function automatic lp_entry_t lp_pick(input logic doze, input logic halt,
                                        input logic tb_off, input logic main_src);
    lp_entry_t e;
    e.valid  = 1'b0;
    e.target = LP_RUN;
    if (halt) begin
      e.valid  = 1'b1;
      e.target = LP_STOP;
    end else if (doze && !tb_off) begin
      e.valid  = 1'b1;
      e.target = LP_TIMEBASE;
    end else if (doze) begin
      e.valid  = 1'b1;
      e.target = main_src ? LP_SLEEP_MN : LP_SLEEP_PLL;
    end
    return e;
  endfunction
endpackage

// File: rtl/lpm_decode.sv
module lpm_decode
  import lpm_pkg::*;
(
  input  logic      doze,
  input  logic      halt,
  input  logic      tb_off,
  input  logic      main_src,
  output lp_entry_t entry
);
  assign entry = lp_pick(doze, halt, tb_off, main_src);

  always_comb begin
    if (halt) a_stop_wins_r3 : assert (entry.target == LP_STOP);
    if (!doze && !halt) a_noop_r5 : assert (!entry.valid);
  end
endmodule

// File: rtl/lpm_state_reg.sv
module lpm_state_reg
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      irq_pending,
  input  lp_entry_t entry,
  output lp_state_e state,
  output logic      take_entry,
  output logic      take_wake
);
  lp_state_e state_q, state_d;
  logic      in_run;

  assign in_run     = (state_q == LP_RUN);
  assign take_entry = in_run && wr_en && entry.valid && !irq_pending;
  assign take_wake  = !in_run && irq_pending;

  always_comb begin
    state_d = state_q;
    if (take_entry)     state_d = entry.target;
    else if (take_wake) state_d = LP_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LP_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;

  p_onehot_r12 : assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q) == 1);
  p_irq_blocks_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && wr_en && irq_pending) |=> (state_q == LP_RUN));
  p_wake_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && irq_pending) |=> (state_q == LP_RUN));
  p_frozen_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && !irq_pending) |=> $stable(state_q));
  p_noop_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && wr_en && !wr_valid_any()) |=> (state_q == LP_RUN));

  function automatic logic wr_valid_any();
    return entry.valid;
  endfunction
endmodule

// File: rtl/lpm_outputs.sv
module lpm_outputs
  import lpm_pkg::*;
#(
  parameter int                NPINS        = 16,
  parameter logic [NPINS-1:0]  BUS_PIN_MASK = 16'h00F0
) (
  input  lp_state_e        state,
  output logic             cpu_clk_en,
  output logic [NPINS-1:0] pin_hold
);
  logic low_power;

  assign low_power  = (state != LP_RUN);
  assign cpu_clk_en = !low_power;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    if (BUS_PIN_MASK[p]) begin : g_bus
      assign pin_hold[p] = 1'b0;
    end else begin : g_gen
      assign pin_hold[p] = low_power;
    end
  end
endmodule

// File: rtl/lpm_entry_ctrl.sv
module lpm_entry_ctrl
  import lpm_pkg::*;
#(
  parameter int               NPINS        = 16,
  parameter logic [NPINS-1:0] BUS_PIN_MASK = 16'h00F0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_doze,
  input  logic                  wr_halt,
  input  logic                  wr_tb_off,
  input  logic                  clk_src_main,
  input  logic                  irq_pending,
  output logic                  cpu_clk_en,
  output logic [LP_NSTATES-1:0] state_onehot,
  output logic [NPINS-1:0]      pin_hold
);
  lp_entry_t entry;
  lp_state_e state;
  logic      take_entry, take_wake;

  lpm_decode u_decode (
    .doze(wr_doze), .halt(wr_halt), .tb_off(wr_tb_off),
    .main_src(clk_src_main), .entry(entry)
  );

  lpm_state_reg u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_pending(irq_pending),
    .entry(entry), .state(state), .take_entry(take_entry), .take_wake(take_wake)
  );

  lpm_outputs #(.NPINS(NPINS), .BUS_PIN_MASK(BUS_PIN_MASK)) u_out (
    .state(state), .cpu_clk_en(cpu_clk_en), .pin_hold(pin_hold)
  );

  assign state_onehot = state;

  p_sleep_flavour_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (take_entry && wr_doze && wr_tb_off && !wr_halt) |=>
      (state_onehot == ($past(clk_src_main) ? 5'b00100 : 5'b00010)));
  p_timebase_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (take_entry && wr_doze && !wr_tb_off && !wr_halt) |=> (state_onehot == 5'b10000));
  p_gate_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    take_wake |=> cpu_clk_en);
  p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> (pin_hold == ~BUS_PIN_MASK));
  p_nohold_run_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (pin_hold == '0));
endmodule

// File: tb/lpm_entry_ctrl_tb.sv
module lpm_entry_ctrl_tb;
  localparam int          NP   = 16;
  localparam logic [15:0] BUSM = 16'h00F0;
  localparam logic [4:0]  S_RUN = 5'b00001, S_PLL = 5'b00010, S_MAIN = 5'b00100,
                          S_STOP = 5'b01000, S_TB = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_doze = 0, wr_halt = 0, wr_tb_off = 0, clk_src_main = 0, irq_pending = 0;
  logic cpu_clk_en;
  logic [4:0] state_onehot;
  logic [NP-1:0] pin_hold;

  int checks = 0, failures = 0, cyc = 0;

  typedef struct { logic [4:0] st; string req; } exp_t;
  exp_t q[$];

  lpm_entry_ctrl #(.NPINS(NP), .BUS_PIN_MASK(BUSM)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_doze(wr_doze), .wr_halt(wr_halt),
    .wr_tb_off(wr_tb_off), .clk_src_main(clk_src_main), .irq_pending(irq_pending),
    .cpu_clk_en(cpu_clk_en), .state_onehot(state_onehot), .pin_hold(pin_hold)
  );

  always #5 clk = ~clk;

  task automatic check_all(input logic [4:0] st, input string req);
    logic [NP-1:0] hold_exp;
    hold_exp = (st == S_RUN) ? '0 : ~BUSM;
    checks++;
    if (state_onehot !== st) begin
      failures++;
      $display("FAIL %s state act=%b exp=%b", req, state_onehot, st);
    end
    checks++;
    if (cpu_clk_en !== (st == S_RUN)) begin
      failures++;
      $display("FAIL R7 cpu_clk_en act=%b exp=%b", cpu_clk_en, st == S_RUN);
    end
    checks++;
    if (pin_hold !== hold_exp) begin
      failures++;
      $display("FAIL R8 pin_hold act=%h exp=%h", pin_hold, hold_exp);
    end
    checks++;
    if ($countones(state_onehot) != 1) begin
      failures++;
      $display("FAIL R12 onehot act=%b exp=one bit", state_onehot);
    end
  endtask

  // Driver: apply one cycle of stimulus, push the expected state after the edge.
  task automatic step(input logic w, input logic d, input logic h, input logic t,
                      input logic m, input logic irq, input logic [4:0] st, input string req);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_doze = d; wr_halt = h; wr_tb_off = t; clk_src_main = m; irq_pending = irq;
    @(posedge clk);
    e.st = st; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compare one item per falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check_all(e.st, e.req);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #12;
    check_all(S_RUN, "R1");
    rst_n = 1'b1;
    // R2 PLL sleep, then R11 writes ignored, R9 wake
    step(1,1,0,1,0,0, S_PLL,  "R2");
    step(0,0,0,0,0,0, S_PLL,  "R11");
    step(1,0,1,1,0,0, S_PLL,  "R11");
    step(1,1,1,0,1,1, S_RUN,  "R9");
    // R2 main sleep
    step(1,1,0,1,1,0, S_MAIN, "R2");
    step(0,0,0,0,0,1, S_RUN,  "R9");
    // R3 stop with doze also set
    step(1,1,1,0,0,0, S_STOP, "R3");
    step(0,0,0,0,0,1, S_RUN,  "R9");
    step(1,0,1,1,1,0, S_STOP, "R3");
    step(0,0,0,0,0,1, S_RUN,  "R9");
    // R4 timebase
    step(1,1,0,0,1,0, S_TB,   "R4");
    step(0,0,0,0,0,0, S_TB,   "R11");
    step(0,0,0,0,0,1, S_RUN,  "R9");
    // R5 no-op write
    step(1,0,0,1,0,0, S_RUN,  "R5");
    step(1,0,0,0,1,0, S_RUN,  "R5");
    // R6 write coinciding with interrupt
    step(1,1,0,1,0,1, S_RUN,  "R6");
    step(1,0,1,0,0,1, S_RUN,  "R6");
    step(1,1,0,0,0,1, S_RUN,  "R6");
    // R10 reset out of sleep
    step(1,1,0,1,1,0, S_MAIN, "R2");
    @(negedge clk);
    wr_en = 0; wr_doze = 0; wr_halt = 0; wr_tb_off = 0;
    #2 rst_n = 1'b0;
    #1 check_all(S_RUN, "R10");
    @(negedge clk);
    rst_n = 1'b1;
    step(1,1,0,1,0,0, S_PLL,  "R2");
    step(0,0,0,0,0,1, S_RUN,  "R9");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule